// File: doc/BRIEF.md
# Dual-Tone Direct Digital Synthesis Channel

This block produces one converter channel's sample stream. In tone mode each output sample is the sum of two sine tones. Every tone has its own phase accumulator, its own 16-bit frequency step, a 16-bit start phase and a signed amplitude factor. The two tones are added and the sum is clipped to the signed 16-bit range. A select input can instead pass an external sample stream through without change, or emit silence.

The tone settings arrive on plain configuration pins, which are normally driven by a register bank. They do not affect the output until a one-cycle `sync_i` pulse. That pulse copies all six settings into the active set together, returns both accumulators to zero and drops any samples still in the pipeline. Several channels that share the pulse therefore restart in phase. Samples leave on a valid/ready interface. A sample whose valid is high stays on the port unchanged until it is taken, with one exception: a `sync_i` pulse drops it. The external stream enters through a second valid/ready interface. Its ready follows the output side combinationally and never waits on its own valid.

Top module: `dds_dual_tone_chan`

## Requirements
- R1: For tone t, the frequency step is bits [15:0] and the start phase is bits [31:16] of its 32-bit configuration word. The output sample with index n after a sync (n = 0, 1, ...) uses the phase (n × step + start) mod 65536, so the step 0x8000 alternates between two phases.
- R2: A phase p maps to a sine value through a 256-entry quarter table. The quadrant is q = p[15:14] and the index is i = p[13:6]. The table position is k = 255 − i when q[0] = 1, otherwise k = i. The magnitude is floor(32767 × (2k+1) × (1023 − 2k) / 262144), and the value is negative when q[1] = 1.
- R3: The amplitude word is sign-magnitude. Bit 15 is the sign and bits 14:0 are the magnitude, with 14 fraction bits. A tone's contribution is floor(sine × magnitude / 16384), negated when the sign bit is 1.
- R4: The two contributions are added and the sum is clipped to the range −32768..32767; it never wraps.
- R5: A `sync_i` pulse loads all six settings, sets both accumulators to zero and removes pending samples. Output valid is low in the next cycle, and the next sample delivered is index 0.
- R6: Changes on the configuration pins have no effect on the output until the next `sync_i`.
- R7: With `out_ready_i` held high, the first valid sample after a sync appears 3 clock edges after the edge that sampled `sync_i`.
- R8: `src_sel_i` = 0 selects the tone sum. `src_sel_i` = 2 passes external samples through in order and unchanged. Any other code outputs zero samples.
- R9: While `out_valid_o` is high and `out_ready_i` is low (and no sync), the output sample and its valid hold. The accumulators do not advance, so no sample is lost or repeated.
- R10: `ext_ready_o` is high exactly when `src_sel_i` = 2, `sync_i` is low, and either `out_ready_i` is high or no output sample is pending.
- R11: After reset `out_valid_o` is low, `out_data_o` is zero and the active amplitudes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Loads settings, restarts accumulators, flushes pipeline |
| src_sel_i | input | 4 | Output source: 0 tones, 2 external, other zero |
| tone0_scale_i | input | 16 | Tone 0 amplitude, sign-magnitude 1.1.14 |
| tone0_fp_i | input | 32 | Tone 0 start phase [31:16], frequency step [15:0] |
| tone1_scale_i | input | 16 | Tone 1 amplitude, sign-magnitude 1.1.14 |
| tone1_fp_i | input | 32 | Tone 1 start phase [31:16], frequency step [15:0] |
| ext_valid_i | input | 1 | External sample valid |
| ext_ready_o | output | 1 | External sample accepted when high with valid |
| ext_data_i | input | 16 | External sample |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Downstream accepts the output sample |
| out_data_o | output | 16 | Output sample, signed |

## Verification
A wrong accumulator, table entry or scaling step shows up as a wrong value in the first affected sample, 3 edges after its accumulator value. Every sample index is compared against an arithmetic model, so the error is caught on that sample. The bench sweeps every table position in all four quadrants. A wrong valid or stall behaviour shows up as a shifted index: every sample from that point on mismatches, or the run falls short of its count. A lost sync or an early load of settings shows up within the first three samples after the pulse, or at the point mid-run where the configuration pins change.

// File: rtl/dds_dual_tone_pkg.sv
`timescale 1ns/1ps
package dds_dual_tone_pkg;

  typedef enum logic [1:0] {
    SRC_TONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_ZERO = 2'd2
  } src_e;

  // quarter-wave entry k of n, sampled at the centre of its slot
  function automatic int quarter_amp(int k, int n, int amp);
    longint num;
    num = longint'(amp) * longint'(2 * k + 1) * longint'(4 * n - 2 * k - 1);
    return int'(num / (longint'(4) * n * n));
  endfunction

endpackage

// File: rtl/dds_sine_rom.sv
`timescale 1ns/1ps
module dds_sine_rom
  import dds_dual_tone_pkg::*;
#(
  parameter int unsigned LUT_AW = 8,
  parameter int unsigned SMP_W  = 16
) (
  input  logic [LUT_AW+1:0]        lut_ph_i,
  output logic signed [SMP_W-1:0]  sine_o
);
  localparam int N   = 1 << LUT_AW;
  localparam int AMP = (1 << (SMP_W - 1)) - 1;

  logic [SMP_W-2:0]  tbl [N];
  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx;
  logic [LUT_AW-1:0] addr;
  logic [SMP_W-2:0]  mag;

  for (genvar k = 0; k < N; k++) begin : g_tbl
    assign tbl[k] = (SMP_W-1)'(quarter_amp(k, N, AMP));
  end

  assign quad = lut_ph_i[LUT_AW+1:LUT_AW];
  assign idx  = lut_ph_i[LUT_AW-1:0];
  assign addr = quad[0] ? ~idx : idx;
  assign mag  = tbl[addr];

  always_comb begin
    if (quad[1]) sine_o = -$signed({1'b0, mag});
    else         sine_o =  $signed({1'b0, mag});
  end

endmodule

// File: rtl/dds_tone_lane.sv
`timescale 1ns/1ps
module dds_tone_lane #(
  parameter int unsigned PH_W     = 16,
  parameter int unsigned LUT_AW   = 8,
  parameter int unsigned SMP_W    = 16,
  parameter int unsigned SCL_W    = 16,
  parameter int unsigned SCL_FRAC = 14,
  localparam int unsigned CW      = SMP_W + SCL_W - SCL_FRAC
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    sync_i,
  input  logic [2*PH_W-1:0]       cfg_fp_i,
  input  logic [SCL_W-1:0]        cfg_scale_i,
  output logic signed [CW-1:0]    contrib_o
);
  localparam int unsigned PW = SMP_W + SCL_W;

  logic [2*PH_W-1:0]        act_fp_q;
  logic [SCL_W-1:0]         act_sc_q;
  logic [PH_W-1:0]          acc_q;
  logic [LUT_AW+1:0]        lut_ph;
  logic signed [SMP_W-1:0]  sine_w;
  logic signed [SMP_W-1:0]  sine_q;
  logic signed [PW-1:0]     prod_w;
  logic signed [CW-1:0]     mag_w;
  logic signed [CW-1:0]     contrib_w;
  logic signed [CW-1:0]     contrib_q;

  // phase = accumulator + start phase, top bits address the table
  assign lut_ph = (LUT_AW+2)'((acc_q + act_fp_q[2*PH_W-1:PH_W]) >> (PH_W - LUT_AW - 2));

  dds_sine_rom #(
    .LUT_AW (LUT_AW),
    .SMP_W  (SMP_W)
  ) u_rom (
    .lut_ph_i (lut_ph),
    .sine_o   (sine_w)
  );

  // sign-magnitude amplitude, floor after the fraction shift
  assign prod_w    = sine_q * $signed({1'b0, act_sc_q[SCL_W-2:0]});
  assign mag_w     = CW'(prod_w >>> SCL_FRAC);
  assign contrib_w = act_sc_q[SCL_W-1] ? -mag_w : mag_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_fp_q  <= '0;
      act_sc_q  <= '0;
      acc_q     <= '0;
      sine_q    <= '0;
      contrib_q <= '0;
    end else begin
      if (sync_i) begin
        act_fp_q <= cfg_fp_i;
        act_sc_q <= cfg_scale_i;
        acc_q    <= '0;
      end else if (en_i) begin
        acc_q <= acc_q + act_fp_q[PH_W-1:0];
      end
      if (en_i) begin
        sine_q    <= sine_w;
        contrib_q <= contrib_w;
      end
    end
  end

  assign contrib_o = contrib_q;

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !sync_i |=> $stable(acc_q)); // R9

  AST_CFG_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> $stable(act_fp_q) && $stable(act_sc_q)); // R6

endmodule

// File: rtl/dds_dual_tone_chan.sv
`timescale 1ns/1ps
module dds_dual_tone_chan
  import dds_dual_tone_pkg::*;
#(
  parameter int unsigned PH_W     = 16,
  parameter int unsigned LUT_AW   = 8,
  parameter int unsigned SMP_W    = 16,
  parameter int unsigned SCL_W    = 16,
  parameter int unsigned SCL_FRAC = 14,
  parameter int unsigned SEL_W    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic [SEL_W-1:0]   src_sel_i,
  input  logic [SCL_W-1:0]   tone0_scale_i,
  input  logic [2*PH_W-1:0]  tone0_fp_i,
  input  logic [SCL_W-1:0]   tone1_scale_i,
  input  logic [2*PH_W-1:0]  tone1_fp_i,
  input  logic               ext_valid_i,
  output logic               ext_ready_o,
  input  logic [SMP_W-1:0]   ext_data_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [SMP_W-1:0]   out_data_o
);
  localparam int unsigned CW    = SMP_W + SCL_W - SCL_FRAC;
  localparam int unsigned SUM_W = CW + 1;
  localparam int unsigned NT    = 2;
  localparam logic [SEL_W-1:0] SEL_TONE = '0;
  localparam logic [SEL_W-1:0] SEL_EXT  = SEL_W'(2);
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 << (SMP_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = ~SAT_HI;

  logic [2*PH_W-1:0]     cfg_fp [NT];
  logic [SCL_W-1:0]      cfg_sc [NT];
  logic signed [CW-1:0]  contrib [NT];

  src_e                    src_w;
  logic                    adv;
  logic                    v0;
  logic                    v1_q, v2_q, v3_q;
  src_e                    sel1_q, sel2_q;
  logic [SMP_W-1:0]        ext1_q, ext2_q;
  logic [SMP_W-1:0]        out_q;
  logic signed [SUM_W-1:0] sum_w;
  logic [SMP_W-1:0]        sat_w;
  logic [SMP_W-1:0]        mux_w;

  assign cfg_fp[0] = tone0_fp_i;
  assign cfg_fp[1] = tone1_fp_i;
  assign cfg_sc[0] = tone0_scale_i;
  assign cfg_sc[1] = tone1_scale_i;

  for (genvar g = 0; g < NT; g++) begin : g_lane
    dds_tone_lane #(
      .PH_W     (PH_W),
      .LUT_AW   (LUT_AW),
      .SMP_W    (SMP_W),
      .SCL_W    (SCL_W),
      .SCL_FRAC (SCL_FRAC)
    ) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (adv),
      .sync_i      (sync_i),
      .cfg_fp_i    (cfg_fp[g]),
      .cfg_scale_i (cfg_sc[g]),
      .contrib_o   (contrib[g])
    );
  end

  // source decode
  always_comb begin
    if (src_sel_i == SEL_TONE)     src_w = SRC_TONE;
    else if (src_sel_i == SEL_EXT) src_w = SRC_EXT;
    else                           src_w = SRC_ZERO;
  end

  // whole pipeline moves when the output slot is free or being taken
  assign adv         = out_ready_i || !v3_q;
  assign v0          = (src_w == SRC_EXT) ? ext_valid_i : 1'b1;
  assign ext_ready_o = adv && (src_w == SRC_EXT) && !sync_i;

  // two-tone sum with clipping
  assign sum_w = {contrib[0][CW-1], contrib[0]} + {contrib[1][CW-1], contrib[1]};

  always_comb begin
    if (sum_w > SAT_HI)      sat_w = SAT_HI[SMP_W-1:0];
    else if (sum_w < SAT_LO) sat_w = SAT_LO[SMP_W-1:0];
    else                     sat_w = sum_w[SMP_W-1:0];
  end

  always_comb begin
    case (sel2_q)
      SRC_TONE: mux_w = sat_w;
      SRC_EXT:  mux_w = ext2_q;
      default:  mux_w = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      v3_q   <= 1'b0;
      sel1_q <= SRC_ZERO;
      sel2_q <= SRC_ZERO;
      ext1_q <= '0;
      ext2_q <= '0;
      out_q  <= '0;
    end else if (sync_i) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else if (adv) begin
      v1_q   <= v0;
      v2_q   <= v1_q;
      v3_q   <= v2_q;
      sel1_q <= src_w;
      sel2_q <= sel1_q;
      ext1_q <= ext_data_i;
      ext2_q <= ext1_q;
      out_q  <= mux_w;
    end
  end

  assign out_valid_o = v3_q;
  assign out_data_o  = out_q;

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !sync_i |=> out_valid_o && $stable(out_data_o)); // R9

  AST_SYNC_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !out_valid_o); // R5

  AST_EXT_READY_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_ready_o |-> src_sel_i == SEL_EXT); // R10

  AST_CLIP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && !sync_i && sel2_q == SRC_TONE && sum_w > SAT_HI
    |=> out_data_o == SAT_HI[SMP_W-1:0]); // R4

  AST_CLIP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && !sync_i && sel2_q == SRC_TONE && sum_w < SAT_LO
    |=> out_data_o == SAT_LO[SMP_W-1:0]); // R4

endmodule

// File: tb/dds_dual_tone_chan_tb_top.sv
`timescale 1ns/1ps
module dds_dual_tone_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic [3:0]  src_sel = 4'd0;
  logic [15:0] sc0 = '0, sc1 = '0;
  logic [31:0] fp0 = '0, fp1 = '0;
  logic        ext_valid = 1'b0;
  logic        ext_ready;
  logic [15:0] ext_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  dds_dual_tone_chan dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .sync_i        (sync),
    .src_sel_i     (src_sel),
    .tone0_scale_i (sc0),
    .tone0_fp_i    (fp0),
    .tone1_scale_i (sc1),
    .tone1_fp_i    (fp1),
    .ext_valid_i   (ext_valid),
    .ext_ready_o   (ext_ready),
    .ext_data_i    (ext_data),
    .out_valid_o   (out_valid),
    .out_ready_i   (out_ready),
    .out_data_o    (out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sine_ref(int unsigned p);
    int unsigned q   = (p >> 14) & 3;
    int unsigned idx = (p >> 6) & 255;
    int unsigned k   = (q & 1) ? 255 - idx : idx;
    longint m = longint'(32767) * longint'(2 * k + 1) * longint'(1023 - 2 * k) / 262144;
    return (q & 2) ? -m : m;
  endfunction

  function automatic longint tone_ref(logic [31:0] fp, logic [15:0] sc, int n);
    longint acc  = (longint'(n) * longint'(fp[15:0])) & 64'hFFFF;
    longint p    = (acc + longint'(fp[31:16])) & 64'hFFFF;
    longint prod = sine_ref(int'(p)) * longint'(sc[14:0]);
    longint t    = prod >>> 14;
    return sc[15] ? -t : t;
  endfunction

  function automatic longint sample_ref(logic [31:0] a_fp, logic [15:0] a_sc,
                                        logic [31:0] b_fp, logic [15:0] b_sc, int n);
    longint s = tone_ref(a_fp, a_sc, n) + tone_ref(b_fp, b_sc, n);
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  function automatic logic [15:0] ext_val(int i);
    return 16'((i * 40503 + 7) ^ (i << 9));
  endfunction

  task automatic pulse_sync();
    @(negedge clk);
    sync = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    sync = 1'b0;
  endtask

  task automatic run_tone(input logic [31:0] a_fp, input logic [15:0] a_sc,
                          input logic [31:0] b_fp, input logic [15:0] b_sc,
                          input int nsamp, input bit stall, input bit change_mid,
                          input string req);
    int k = 1;
    int n = 0;
    int cyc = 0;
    bit prev_stall = 1'b0;
    logic [15:0] prev_data = '0;
    @(negedge clk);
    src_sel = 4'd0;
    fp0 = a_fp; sc0 = a_sc; fp1 = b_fp; sc1 = b_sc;
    pulse_sync();
    // R7: first valid output three edges after the sync edge
    while (!out_valid && k < 10) begin
      @(negedge clk);
      k++;
    end
    check(k == 4, "R7 latency", k - 1, 3);
    check(ext_ready == 1'b0, "R10 ext_ready in tone mode", ext_ready, 0);
    while (n < nsamp && cyc < nsamp * 4 + 20) begin
      bit rdy = stall ? ((cyc % 3) != 2) : 1'b1;
      if (prev_stall)
        check(out_valid && out_data == prev_data, "R9 stall hold", out_data, prev_data);
      out_ready = rdy;
      if (change_mid && n == nsamp / 2) begin
        fp0 = ~a_fp; sc0 = a_sc ^ 16'h2A5A;
        fp1 = b_fp + 32'h1357_0101; sc1 = 16'h7FFF;
      end
      if (out_valid && rdy) begin
        longint exp = sample_ref(a_fp, a_sc, b_fp, b_sc, n);
        check(longint'($signed(out_data)) == exp, req, longint'($signed(out_data)), exp);
        n++;
      end
      prev_stall = out_valid && !rdy;
      prev_data  = out_data;
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b1;
    check(n == nsamp, "R9 sample count", n, nsamp);
  endtask

  task automatic run_ext(input int nitems);
    int pushed = 0;
    int popped = 0;
    int cyc = 0;
    @(negedge clk);
    src_sel = 4'd2;
    pulse_sync();
    while (popped < nitems && cyc < nitems * 6 + 40) begin
      bit rdy = (cyc % 5) != 3;
      bit pend = out_valid;
      out_ready = rdy;
      ext_valid = (pushed < nitems) && ((cyc % 4) != 1);
      ext_data  = ext_val(pushed);
      #1;
      check(ext_ready == (rdy || !pend), "R10 ext_ready rule", ext_ready, rdy || !pend);
      if (out_valid && rdy) begin
        check(out_data == ext_val(popped), "R8 external passthrough", out_data, ext_val(popped));
        popped++;
      end
      if (ext_valid && ext_ready) pushed++;
      cyc++;
      @(negedge clk);
    end
    ext_valid = 1'b0;
    out_ready = 1'b1;
    check(popped == nitems, "R8 external count", popped, nitems);
  endtask

  task automatic run_zero(input logic [3:0] code);
    int seen = 0;
    int cyc = 0;
    @(negedge clk);
    src_sel = code;
    fp0 = 32'h0000_0040; sc0 = 16'h4000; fp1 = 32'h4000_0000; sc1 = 16'h4000;
    pulse_sync();
    while (seen < 16 && cyc < 60) begin
      if (out_valid) begin
        check(out_data == 16'd0, "R8 other select outputs zero", out_data, 0);
        seen++;
      end
      cyc++;
      @(negedge clk);
    end
    check(seen == 16, "R8 zero count", seen, 16);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL R7 watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(out_valid == 1'b0, "R11 reset valid", out_valid, 0);
    check(out_data == 16'd0, "R11 reset data", out_data, 0);
    check(ext_ready == 1'b0, "R11 reset ext_ready", ext_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid && out_data == 16'd0, "R11 zero amplitude after reset", out_data, 0);

    // R2: full table sweep, all quadrants, unity amplitude on tone 0
    run_tone(32'h0000_0040, 16'h4000, 32'h0000_0000, 16'h0000, 1024, 1'b0, 1'b0, "R2 table sweep");
    // R3: negative half amplitude on tone 1 with an odd start phase, with stalls
    run_tone(32'h0000_0000, 16'h0000, 32'h1234_0040, 16'hA000, 1024, 1'b1, 1'b0, "R3 signed scale");
    // R1: half-rate step and odd steps together
    run_tone(32'h4000_8000, 16'h3FFF, 32'hC000_0123, 16'h2001, 300, 1'b0, 1'b0, "R1 frequency step");
    // R4: both clip limits
    run_tone(32'h4000_0000, 16'h7FFF, 32'h4000_0000, 16'h7FFF, 8, 1'b0, 1'b0, "R4 clip high");
    run_tone(32'hC000_0000, 16'h7FFF, 32'hC000_0000, 16'h7FFF, 8, 1'b0, 1'b0, "R4 clip low");
    run_tone(32'h0000_8000, 16'h7FFF, 32'h4000_0101, 16'h7C00, 300, 1'b1, 1'b0, "R4 clip mixed");
    // R6: configuration changes without sync are ignored
    run_tone(32'h2222_0333, 16'h5123, 32'h0F00_1001, 16'hC321, 200, 1'b0, 1'b1, "R6 ignore until sync");
    // R5: a fresh sync restarts from index 0 with the new settings
    for (int i = 0; i < 6; i++) begin
      logic [31:0] a, b;
      logic [15:0] s0, s1;
      seed = seed * 32'd1103515245 + 32'd12345; a  = seed;
      seed = seed * 32'd1103515245 + 32'd12345; b  = seed;
      seed = seed * 32'd1103515245 + 32'd12345; s0 = seed[31:16]; s1 = seed[15:0];
      a[15] = 1'b0;
      b[15] = 1'b0;
      run_tone(a, s0, b, s1, 150, i[0], i[1], "R5 restart on sync");
    end
    run_ext(200);
    run_zero(4'd1);
    run_zero(4'd9);
    // R8: back to tones after other modes
    run_tone(32'h0000_0040, 16'h4000, 32'h8000_0020, 16'hC000, 128, 1'b1, 1'b0, "R8 tone select");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule